// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block turns the file-operand field of a byte- or bit-oriented instruction into a 12-bit data-memory address. It is for a small 8-bit controller whose data space is split into sixteen 256-byte banks. The instruction word carries four fields: an opcode, a destination bit, an access-select bit and an 8-bit file field. The access-select bit and the file field choose one of four address sources. Two of these sources depend on the extended-mode enable.

The block holds two registers. One is a 4-bit bank register. The other is a 12-bit pointer, which is loaded as a 4-bit high part and an 8-bit low part. Each register has its own synchronous write strobe. The address path is purely combinational, from the instruction, these registers and the mode enable.

The block reports which address source it used on a 2-bit mode output. A valid strobe passes the instruction-valid input through to the output. The memory array, the arithmetic unit and the instruction fetch sit outside this block.

Top module: `bank_addr_gen`

## Requirements
- R1: When the access bit (instruction bit 8) is 1, the address is `{bank, f}`, where f is instruction bits 7:0, for every f. The mode output is 0.
- R2: When the access bit is 0 and f is 60h or above, the address is F00h + f, whatever the extended enable. The mode output is 1.
- R3: When the access bit is 0, f is 5Fh or below and the extended enable is 1, the address is (pointer + f) modulo 4096. Here f is zero-extended. The mode output is 2.
- R4: When the access bit is 0, f is 5Fh or below and the extended enable is 0, the address is f zero-extended (000h to 05Fh). The mode output is 3.
- R5: The output valid strobe equals the instruction-valid input in the same cycle. The address is also produced while the input is low.
- R6: The bank register takes its write data at a rising clock edge while its write strobe is high. Otherwise it holds its value.
- R7: The pointer high nibble and the pointer low byte load independently, each from its own strobe and data. A write to one leaves the other unchanged.
- R8: An active-high synchronous reset clears the bank register and the pointer to zero. Reset takes priority over the write strobes.
- R9: Instruction bits 15:9 (the opcode and the destination bit) have no effect on the address or the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrWord | input | 16 | Instruction word: opcode[15:10], dest[9], access[8], file[7:0] |
| instrValid | input | 1 | Instruction present this cycle |
| extEnable | input | 1 | Extended (indexed-offset) mode enable |
| bankWrEn | input | 1 | Bank register write strobe |
| bankWrData | input | 4 | Bank register write data |
| ptrHiWrEn | input | 1 | Pointer high-nibble write strobe |
| ptrHiWrData | input | 4 | Pointer high-nibble write data |
| ptrLoWrEn | input | 1 | Pointer low-byte write strobe |
| ptrLoWrData | input | 8 | Pointer low-byte write data |
| effAddr | output | 12 | Effective data-memory address |
| addrMode | output | 2 | Address source: 0 bank, 1 forced top bank, 2 indexed, 3 low direct |
| addrValid | output | 1 | Echo of instrValid |

## Verification
The assertions assume two things about the inputs: reset is held for at least one clock edge before any check, and the instruction word and mode enable are free of X once reset is released. The register-load properties also assume the write data is stable across the edge at which it is sampled. The bench meets these assumptions in three ways. It drives every input to a known value before releasing reset. It changes the write ports only at falling edges. It changes the instruction and the mode enable only between rising edges, so every sampled value is settled.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;

  typedef enum logic [1:0] {
    MODE_BANK      = 2'd0,
    MODE_FORCED    = 2'd1,
    MODE_INDEXED   = 2'd2,
    MODE_LOWDIRECT = 2'd3
  } addrMode_e;

  // one-hot select strobes from control to datapath
  typedef struct packed {
    logic selBank;
    logic selForced;
    logic selIndexed;
    logic selLowDirect;
  } addrSel_t;

endpackage

// File: rtl/bank_addr_ctrl.sv
module bank_addr_ctrl
  import bank_addr_pkg::*;
#(
  parameter int FILE_W       = 8,
  parameter int ACCESS_SPLIT = 96,
  parameter int OPHI_W       = 7
) (
  input  logic [FILE_W+OPHI_W:0] instrWord,
  input  logic                   extEnable,
  output addrSel_t               sel,
  output addrMode_e              mode,
  output logic [FILE_W-1:0]      fileField
);
  localparam int ACC_BIT = FILE_W;
  localparam logic [FILE_W-1:0] SPLIT = FILE_W'(ACCESS_SPLIT);

  logic accessBit;
  logic upperWindow;
  logic unusedOpBits;

  assign fileField    = instrWord[FILE_W-1:0];
  assign accessBit    = instrWord[ACC_BIT];
  assign upperWindow  = (fileField >= SPLIT);
  assign unusedOpBits = ^instrWord[FILE_W+OPHI_W:ACC_BIT+1];

  always_comb begin
    sel  = '0;
    mode = MODE_BANK;
    if (accessBit) begin
      sel.selBank = 1'b1;
      mode        = MODE_BANK;
    end else if (upperWindow) begin
      sel.selForced = 1'b1;
      mode          = MODE_FORCED;
    end else if (extEnable) begin
      sel.selIndexed = 1'b1;
      mode           = MODE_INDEXED;
    end else begin
      sel.selLowDirect = 1'b1;
      mode             = MODE_LOWDIRECT;
    end
  end

endmodule

// File: rtl/bank_addr_dp.sv
module bank_addr_dp
  import bank_addr_pkg::*;
#(
  parameter int FILE_W = 8,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bankWrEn,
  input  logic [BANK_W-1:0] bankWrData,
  input  logic              ptrHiWrEn,
  input  logic [BANK_W-1:0] ptrHiWrData,
  input  logic              ptrLoWrEn,
  input  logic [FILE_W-1:0] ptrLoWrData,
  input  addrSel_t          sel,
  input  logic [FILE_W-1:0] fileField,
  output logic [BANK_W+FILE_W-1:0] effAddr
);
  localparam int ADDR_W = BANK_W + FILE_W;

  logic [BANK_W-1:0] bankReg;
  logic [BANK_W-1:0] ptrHi;
  logic [FILE_W-1:0] ptrLo;
  logic [ADDR_W-1:0] ptrFull;
  logic [ADDR_W-1:0] idxSum;

  always_ff @(posedge clk) begin
    if (rst) bankReg <= '0;
    else if (bankWrEn) bankReg <= bankWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) ptrHi <= '0;
    else if (ptrHiWrEn) ptrHi <= ptrHiWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) ptrLo <= '0;
    else if (ptrLoWrEn) ptrLo <= ptrLoWrData;
  end

  assign ptrFull = {ptrHi, ptrLo};
  assign idxSum  = ptrFull + ADDR_W'(fileField);

  always_comb begin
    effAddr = {{BANK_W{1'b0}}, fileField};
    if (sel.selBank)         effAddr = {bankReg, fileField};
    else if (sel.selForced)  effAddr = {{BANK_W{1'b1}}, fileField};
    else if (sel.selIndexed) effAddr = idxSum;
  end

  a_r6_bank_load: assert property (@(posedge clk) disable iff (rst)
    bankWrEn |=> bankReg == $past(bankWrData));
  a_r6_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !bankWrEn |=> $stable(bankReg));
  a_r7_ptr_hi_load: assert property (@(posedge clk) disable iff (rst)
    ptrHiWrEn |=> ptrHi == $past(ptrHiWrData));
  a_r7_ptr_lo_independent: assert property (@(posedge clk) disable iff (rst)
    (ptrHiWrEn && !ptrLoWrEn) |=> $stable(ptrLo));
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (bankReg == '0 && ptrFull == '0));

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import bank_addr_pkg::*;
#(
  parameter int FILE_W       = 8,
  parameter int BANK_W       = 4,
  parameter int ACCESS_SPLIT = 96,
  parameter int OPHI_W       = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [FILE_W+OPHI_W:0]   instrWord,
  input  logic                     instrValid,
  input  logic                     extEnable,
  input  logic                     bankWrEn,
  input  logic [BANK_W-1:0]        bankWrData,
  input  logic                     ptrHiWrEn,
  input  logic [BANK_W-1:0]        ptrHiWrData,
  input  logic                     ptrLoWrEn,
  input  logic [FILE_W-1:0]        ptrLoWrData,
  output logic [BANK_W+FILE_W-1:0] effAddr,
  output logic [1:0]               addrMode,
  output logic                     addrValid
);
  localparam int ADDR_W = BANK_W + FILE_W;
  localparam logic [ADDR_W-1:0] LOW_LIMIT = ADDR_W'(ACCESS_SPLIT);

  addrSel_t          sel;
  addrMode_e         modeE;
  logic [FILE_W-1:0] fileField;

  bank_addr_ctrl #(.FILE_W(FILE_W), .ACCESS_SPLIT(ACCESS_SPLIT), .OPHI_W(OPHI_W)) u_ctrl (
    .instrWord (instrWord),
    .extEnable (extEnable),
    .sel       (sel),
    .mode      (modeE),
    .fileField (fileField)
  );

  bank_addr_dp #(.FILE_W(FILE_W), .BANK_W(BANK_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .bankWrEn    (bankWrEn),
    .bankWrData  (bankWrData),
    .ptrHiWrEn   (ptrHiWrEn),
    .ptrHiWrData (ptrHiWrData),
    .ptrLoWrEn   (ptrLoWrEn),
    .ptrLoWrData (ptrLoWrData),
    .sel         (sel),
    .fileField   (fileField),
    .effAddr     (effAddr)
  );

  assign addrMode  = modeE;
  assign addrValid = instrValid;

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);
  a_r1_bank_low_byte: assert property (@(posedge clk) disable iff (rst)
    instrWord[FILE_W] |-> effAddr[FILE_W-1:0] == instrWord[FILE_W-1:0]);
  a_r2_forced_top_bank: assert property (@(posedge clk) disable iff (rst)
    addrMode == 2'd1 |-> (&effAddr[ADDR_W-1:FILE_W]) && effAddr >= {{BANK_W{1'b1}}, FILE_W'(ACCESS_SPLIT)});
  a_r4_low_direct_range: assert property (@(posedge clk) disable iff (rst)
    addrMode == 2'd3 |-> effAddr < LOW_LIMIT);
  a_r3_indexed_needs_ext: assert property (@(posedge clk) disable iff (rst)
    addrMode == 2'd2 |-> extEnable && !instrWord[FILE_W]);

endmodule

// File: tb/sim_bank_addr_gen.sv
`timescale 1ns/1ps
module sim_bank_addr_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] instrWord = '0;
  logic instrValid = 1'b0, extEnable = 1'b0;
  logic bankWrEn = 1'b0, ptrHiWrEn = 1'b0, ptrLoWrEn = 1'b0;
  logic [3:0] bankWrData = '0, ptrHiWrData = '0;
  logic [7:0] ptrLoWrData = '0;
  logic [11:0] effAddr;
  logic [1:0] addrMode;
  logic addrValid;

  int errors = 0, checks = 0, cycles = 0;
  int bankM = 0, ptrM = 0;

  always #2.5 clk = ~clk;

  bank_addr_gen u0 (
    .clk(clk), .rst(rst), .instrWord(instrWord), .instrValid(instrValid),
    .extEnable(extEnable), .bankWrEn(bankWrEn), .bankWrData(bankWrData),
    .ptrHiWrEn(ptrHiWrEn), .ptrHiWrData(ptrHiWrData), .ptrLoWrEn(ptrLoWrEn),
    .ptrLoWrData(ptrLoWrData), .effAddr(effAddr), .addrMode(addrMode),
    .addrValid(addrValid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string req, int expA, int expM);
    #1;
    checks++;
    if (effAddr !== 12'(expA) || addrMode !== 2'(expM) || addrValid !== instrValid) begin
      errors++;
      $display("FAIL %s: actual addr=%03h mode=%0d valid=%0b expected addr=%03h mode=%0d valid=%0b",
               req, effAddr, addrMode, addrValid, 12'(expA), expM, instrValid);
    end
  endtask

  function automatic int model(int a, int f, int e);
    if (a == 1) return bankM * 256 + f;
    if (f >= 'h60) return 'hF00 + f;
    if (e == 1) return (ptrM + f) % 4096;
    return f;
  endfunction

  function automatic int modelMode(int a, int f, int e);
    if (a == 1) return 0;
    if (f >= 'h60) return 1;
    if (e == 1) return 2;
    return 3;
  endfunction

  task automatic setInstr(int op, int a, int f, int e);
    instrWord = {6'(op >> 1), 1'(op), 1'(a), 8'(f)};
    extEnable = 1'(e);
  endtask

  task automatic loadBank(int v, bit en);
    @(negedge clk);
    bankWrEn = en; bankWrData = 4'(v);
    @(negedge clk);
    bankWrEn = 1'b0;
    if (en) bankM = v;
  endtask

  task automatic loadPtr(bit hiEn, int hi, bit loEn, int lo);
    @(negedge clk);
    ptrHiWrEn = hiEn; ptrHiWrData = 4'(hi);
    ptrLoWrEn = loEn; ptrLoWrData = 8'(lo);
    @(negedge clk);
    ptrHiWrEn = 1'b0; ptrLoWrEn = 1'b0;
    if (hiEn) ptrM = (ptrM & 'hFF) | (hi << 8);
    if (loEn) ptrM = (ptrM & 'hF00) | lo;
  endtask

  initial begin
    // write strobes asserted during reset must lose to reset (R8)
    bankWrEn = 1'b1; bankWrData = 4'hA; ptrHiWrEn = 1'b1; ptrHiWrData = 4'h3;
    repeat (3) @(negedge clk);
    bankWrEn = 1'b0; ptrHiWrEn = 1'b0;
    rst = 1'b0;
    instrValid = 1'b1;

    // R8: registers read back as zero through the address path
    setInstr(0, 1, 'h34, 0); chk("R8", 'h034, 0);
    setInstr(0, 0, 'h05, 1); chk("R8", 'h005, 2);

    // R5: valid echo both ways
    instrValid = 1'b0; setInstr(5, 1, 'h10, 0); chk("R5", 'h010, 0);
    instrValid = 1'b1; chk("R5", 'h010, 0);

    // R6: hold when strobe is low
    loadBank(9, 1'b0);
    setInstr(0, 1, 'h77, 0); chk("R6", 'h077, 0);

    // R7: independent pointer halves
    loadPtr(1'b1, 'h7, 1'b0, 'hEE);
    setInstr(0, 0, 'h01, 1); chk("R7", 'h701, 2);
    loadPtr(1'b0, 'h2, 1'b1, 'hC0);
    setInstr(0, 0, 'h01, 1); chk("R7", 'h7C1, 2);

    // R1..R4, R9 sweep: every bank, every f, both access values, both enables, two opcodes
    loadPtr(1'b1, 'hA, 1'b1, 'h5C);
    for (int b = 0; b < 16; b++) begin
      loadBank(b, 1'b1);
      for (int f = 0; f < 256; f++)
        for (int a = 0; a < 2; a++)
          for (int e = 0; e < 2; e++) begin
            setInstr((f * 7 + b) & 127, a, f, e);
            chk(a == 1 ? "R1" : (f >= 'h60 ? "R2" : (e == 1 ? "R3" : "R4")),
                model(a, f, e), modelMode(a, f, e));
            setInstr(~(f * 7 + b) & 127, a, f, e);
            chk("R9", model(a, f, e), modelMode(a, f, e));
          end
    end

    // R3: wrap at the top of the space, over all low offsets
    foreach (ptrM_list[i]) begin
      loadPtr(1'b1, ptrM_list[i] >> 8, 1'b1, ptrM_list[i] & 'hFF);
      for (int f = 0; f < 'h60; f++) begin
        setInstr(3, 0, f, 1);
        chk("R3", (ptrM + f) % 4096, 2);
      end
    end

    // R8: reset mid-run clears loaded registers
    loadBank(5, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bankM = 0; ptrM = 0;
    setInstr(0, 1, 'hAB, 0); chk("R8", 'h0AB, 0);
    setInstr(0, 0, 'h5F, 1); chk("R8", 'h05F, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int ptrM_list[4] = '{'hFFF, 'hFA1, 'h000, 'h123};

endmodule